// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This block is the processor-side register port of an interrupt controller. The processor reads an acknowledge register to claim the most urgent pending interrupt. It writes an end-of-interrupt register to retire one. Between those two events the block keeps track of which interrupt is running, at which priority, and which interrupts that one preempted. A separate priority selector supplies the highest pending identifier and its priority. The block answers with requests to clear or re-set the pending bits of single sources.

Nesting is held in a link table with one entry per source. When an interrupt is claimed, its entry records the identifier that was running before it, so the entries form a stack that runs down to the idle identifier 1023. Retiring the running interrupt pops that stack in one extra cycle. Retiring an interrupt from deeper in the stack is also allowed. The unit then follows the chain one entry per clock until it finds the entry that points at the named interrupt, and bypasses that interrupt. While this work is in progress a busy flag is raised, and register strobes are not accepted.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset the running identifier is 1023, the running priority is 0x100, the priority mask is 0x0F0, the interface enable is 0, busy is low and no pending request is pulsed.
- R2: Offset 0x00 holds the interface enable in bit 0. Offset 0x04 holds a 10-bit priority mask taken from write data bits 9:0. Offset 0x08 reads as 0, and writes to it change nothing.
- R3: A read of offset 0x0C returns 1023 and changes no state when the highest pending identifier is 1023, or when its priority is not strictly below the running priority.
- R4: A successful read of offset 0x0C returns the pending identifier and pulses the pending-clear request with that identifier for one cycle. The identifier becomes the running identifier, and its priority becomes the running priority, in the cycle the read data appears.
- R5: Offset 0x14 reads the running priority, and offset 0x18 reads the highest pending identifier input.
- R6: A write to offset 0x10 while the running identifier is 1023 changes nothing: no request is pulsed and busy stays low.
- R7: An end-of-interrupt pulses the pending-set request for its identifier only when that source is level-triggered (edge input 0), enabled and its level input is high.
- R8: Retiring the running interrupt makes the identifier recorded at its claim the new running identifier. A return to 1023 sets the running priority to 0x100; otherwise the running priority is the recorded source's priority.
- R9: Retiring an interrupt that is not the running one leaves the running identifier unchanged. It removes that interrupt from the nesting chain, so that later completions return through the remaining interrupts in their original order.
- R10: Retiring an identifier that is not in the chain, including 1023, leaves the chain unchanged.
- R11: Busy is high from the cycle after an accepted end-of-interrupt until the completion finishes. It lasts at most the number of sources plus two cycles, and strobes presented while busy is high are dropped.
- R12: A read of an unknown or write-only offset returns 0 and pulses the error flag. A write to an unknown or read-only offset pulses the error flag and changes no state.
- R13: An end-of-interrupt write uses only write data bits 9:0 as the identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, accepted when busy is low |
| bus_wr | input | 1 | Write strobe, accepted when busy is low |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle pulse after an accepted read |
| bus_err | output | 1 | One-cycle pulse after an access to a bad offset |
| busy | output | 1 | Completion in progress; strobes are dropped |
| hp_id | input | 10 | Highest pending identifier, 1023 when none |
| hp_prio | input | PRIO_W | Priority of hp_id |
| src_prio | input | NUM_SRC*PRIO_W | Per-source priority, source i at bits i*PRIO_W upward |
| src_edge | input | NUM_SRC | Per-source trigger type, 1 = edge |
| src_en | input | NUM_SRC | Per-source enable |
| src_level | input | NUM_SRC | Per-source input level |
| pend_clr | output | 1 | Pending-clear request pulse |
| pend_clr_id | output | 10 | Source to clear |
| pend_set | output | 1 | Pending-set request pulse |
| pend_set_id | output | 10 | Source to set |
| run_id | output | 10 | Running identifier, 1023 when idle |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 when idle |
| if_enable | output | 1 | Interface enable bit |
| prio_mask | output | 10 | Priority mask |

## Verification
The assertions assume a well-formed priority selector. The pending identifier is either 1023 or a valid source number, and it is never a source that is already on the nesting chain. Read and write strobes are never raised together. The bench respects these limits. It builds every nesting depth by claiming sources in rising order, with strictly falling priorities. It presents only pending identifiers it has not claimed yet. It waits for busy to drop before every access, except in the one case that deliberately tests a dropped strobe. Trigger types, enables and levels are varied arithmetically from the depth and the retire position. This lets every combination that affects the pending-set request appear.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = '1;

  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_MASK  = 'h04;
  localparam int OFS_BPT   = 'h08;
  localparam int OFS_ACK   = 'h0C;
  localparam int OFS_EOI   = 'h10;
  localparam int OFS_RPRI  = 'h14;
  localparam int OFS_HPEND = 'h18;

  localparam logic [ID_W-1:0] MASK_RESET = 10'h0F0;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_RD_CTRL,
    OP_RD_MASK,
    OP_RD_BPT,
    OP_RD_ACK,
    OP_RD_RPRI,
    OP_RD_HPEND,
    OP_WR_CTRL,
    OP_WR_MASK,
    OP_WR_BPT,
    OP_WR_EOI,
    OP_BAD_RD,
    OP_BAD_WR
  } acc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_POP,
    ST_WALK,
    ST_SPLICE
  } trk_state_e;
endpackage

// File: rtl/icpu_decode.sv
module icpu_decode
  import icpu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              accept,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output acc_op_e           op
);
  always_comb begin
    op = OP_NONE;
    if (accept && rd) begin
      case (addr)
        ADDR_W'(OFS_CTRL):  op = OP_RD_CTRL;
        ADDR_W'(OFS_MASK):  op = OP_RD_MASK;
        ADDR_W'(OFS_BPT):   op = OP_RD_BPT;
        ADDR_W'(OFS_ACK):   op = OP_RD_ACK;
        ADDR_W'(OFS_RPRI):  op = OP_RD_RPRI;
        ADDR_W'(OFS_HPEND): op = OP_RD_HPEND;
        default:            op = OP_BAD_RD;
      endcase
    end else if (accept && wr) begin
      case (addr)
        ADDR_W'(OFS_CTRL): op = OP_WR_CTRL;
        ADDR_W'(OFS_MASK): op = OP_WR_MASK;
        ADDR_W'(OFS_BPT):  op = OP_WR_BPT;
        ADDR_W'(OFS_EOI):  op = OP_WR_EOI;
        default:           op = OP_BAD_WR;
      endcase
    end
  end
endmodule

// File: rtl/icpu_link_ram.sv
module icpu_link_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 10,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata
);
  // Plain array with one registered read port and one write port, no reset.
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/icpu_nest_tracker.sv
module icpu_nest_tracker
  import icpu_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int CNT_W  = $clog2(NUM_SRC + 4) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      acc_ack,
  input  logic                      acc_eoi,
  input  logic [ID_W-1:0]           eoi_id,
  input  logic [ID_W-1:0]           hp_id,
  input  logic [PRIO_W-1:0]         hp_prio,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [NUM_SRC-1:0]        src_edge,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC-1:0]        src_level,
  input  logic [ID_W-1:0]           ram_q,
  output logic                      ram_re,
  output logic [IDX_W-1:0]          ram_raddr,
  output logic                      ram_we,
  output logic [IDX_W-1:0]          ram_waddr,
  output logic [ID_W-1:0]           ram_wdata,
  output logic                      ack_ok,
  output logic                      busy,
  output logic [ID_W-1:0]           run_id,
  output logic [PRIO_W:0]           run_prio,
  output logic                      pend_clr,
  output logic [ID_W-1:0]           pend_clr_id,
  output logic                      pend_set,
  output logic [ID_W-1:0]           pend_set_id
);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};
  localparam logic [CNT_W-1:0] STEP_LIMIT = CNT_W'(NUM_SRC);

  trk_state_e       state;
  logic [IDX_W-1:0] cur;
  logic [ID_W-1:0]  target;
  logic [CNT_W-1:0] steps;

  logic             hp_valid, eoi_live, eoi_in_range, relevel;
  logic             walk_end, walk_hit;
  logic [PRIO_W-1:0] q_prio;

  assign busy         = (state != ST_IDLE);
  assign hp_valid     = (hp_id != NO_IRQ) && (hp_id < ID_W'(NUM_SRC));
  assign ack_ok       = acc_ack && hp_valid && ({1'b0, hp_prio} < run_prio);
  assign eoi_live     = acc_eoi && (run_id != NO_IRQ);
  assign eoi_in_range = (eoi_id < ID_W'(NUM_SRC));
  assign relevel      = eoi_in_range && !src_edge[eoi_id[IDX_W-1:0]]
                        && src_en[eoi_id[IDX_W-1:0]] && src_level[eoi_id[IDX_W-1:0]];
  assign q_prio       = src_prio[ram_q[IDX_W-1:0]*PRIO_W +: PRIO_W];
  assign walk_end     = (ram_q == NO_IRQ) || (steps == STEP_LIMIT);
  assign walk_hit     = (ram_q == target);

  // Link table port control
  always_comb begin
    ram_re    = 1'b0;
    ram_raddr = cur;
    ram_we    = 1'b0;
    ram_waddr = cur;
    ram_wdata = ram_q;
    unique case (state)
      ST_IDLE: begin
        if (ack_ok) begin
          ram_we    = 1'b1;
          ram_waddr = hp_id[IDX_W-1:0];
          ram_wdata = run_id;
        end else if (eoi_live) begin
          ram_re    = 1'b1;
          ram_raddr = run_id[IDX_W-1:0];
        end
      end
      ST_WALK: begin
        if (!walk_end) begin
          ram_re    = 1'b1;
          ram_raddr = walk_hit ? target[IDX_W-1:0] : ram_q[IDX_W-1:0];
        end
      end
      ST_SPLICE: begin
        ram_we    = 1'b1;
        ram_waddr = cur;
        ram_wdata = ram_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      run_id      <= NO_IRQ;
      run_prio    <= IDLE_PRIO;
      pend_clr    <= 1'b0;
      pend_clr_id <= '0;
      pend_set    <= 1'b0;
      pend_set_id <= '0;
      cur         <= '0;
      target      <= '0;
      steps       <= '0;
    end else begin
      pend_clr <= 1'b0;
      pend_set <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ack_ok) begin
            run_id      <= hp_id;
            run_prio    <= {1'b0, hp_prio};
            pend_clr    <= 1'b1;
            pend_clr_id <= hp_id;
          end else if (eoi_live) begin
            pend_set    <= relevel;
            pend_set_id <= eoi_id;
            target      <= eoi_id;
            cur         <= run_id[IDX_W-1:0];
            steps       <= '0;
            state       <= (eoi_id == run_id) ? ST_POP : ST_WALK;
          end
        end
        ST_POP: begin
          run_id   <= ram_q;
          run_prio <= (ram_q == NO_IRQ) ? IDLE_PRIO : {1'b0, q_prio};
          state    <= ST_IDLE;
        end
        ST_WALK: begin
          if (walk_end) begin
            state <= ST_IDLE;
          end else if (walk_hit) begin
            state <= ST_SPLICE;
          end else begin
            cur   <= ram_q[IDX_W-1:0];
            steps <= steps + 1'b1;
          end
        end
        ST_SPLICE: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // Busy-length counter used only by the bound check below
  logic [CNT_W-1:0] busy_run;
  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= '0;
    else if (busy_run != '1) busy_run <= busy_run + 1'b1;
  end

  a_r4_claim_takes_over: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && ack_ok) |=> (run_id == $past(hp_id)) && pend_clr
                                      && (pend_clr_id == $past(hp_id)));

  a_r3_refused_claim_no_change: assert property (@(posedge clk) disable iff (rst)
    (acc_ack && !ack_ok) |=> $stable(run_id) && $stable(run_prio) && !pend_clr);

  a_r6_idle_eoi_ignored: assert property (@(posedge clk) disable iff (rst)
    (acc_eoi && run_id == NO_IRQ) |=> !busy && !pend_set && $stable(run_id));

  a_r8_idle_priority: assert property (@(posedge clk) disable iff (rst)
    (run_id == NO_IRQ) |-> (run_prio == IDLE_PRIO));

  a_r11_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run <= CNT_W'(NUM_SRC + 2)));

  a_r7_one_request: assert property (@(posedge clk) disable iff (rst)
    !(pend_set && pend_clr));
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import icpu_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_rd,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      bus_rvalid,
  output logic                      bus_err,
  output logic                      busy,
  input  logic [ID_W-1:0]           hp_id,
  input  logic [PRIO_W-1:0]         hp_prio,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [NUM_SRC-1:0]        src_edge,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC-1:0]        src_level,
  output logic                      pend_clr,
  output logic [ID_W-1:0]           pend_clr_id,
  output logic                      pend_set,
  output logic [ID_W-1:0]           pend_set_id,
  output logic [ID_W-1:0]           run_id,
  output logic [PRIO_W:0]           run_prio,
  output logic                      if_enable,
  output logic [ID_W-1:0]           prio_mask
);
  acc_op_e          op;
  logic             ack_ok;
  logic             ram_re, ram_we;
  logic [IDX_W-1:0] ram_raddr, ram_waddr;
  logic [ID_W-1:0]  ram_wdata, ram_q;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:ID_W];

  icpu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .accept (!busy),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .op     (op)
  );

  icpu_link_ram #(.DEPTH(NUM_SRC), .WIDTH(ID_W)) u_links (
    .clk   (clk),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_q),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata)
  );

  icpu_nest_tracker #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_trk (
    .clk         (clk),
    .rst         (rst),
    .acc_ack     (op == OP_RD_ACK),
    .acc_eoi     (op == OP_WR_EOI),
    .eoi_id      (bus_wdata[ID_W-1:0]),
    .hp_id       (hp_id),
    .hp_prio     (hp_prio),
    .src_prio    (src_prio),
    .src_edge    (src_edge),
    .src_en      (src_en),
    .src_level   (src_level),
    .ram_q       (ram_q),
    .ram_re      (ram_re),
    .ram_raddr   (ram_raddr),
    .ram_we      (ram_we),
    .ram_waddr   (ram_waddr),
    .ram_wdata   (ram_wdata),
    .ack_ok      (ack_ok),
    .busy        (busy),
    .run_id      (run_id),
    .run_prio    (run_prio),
    .pend_clr    (pend_clr),
    .pend_clr_id (pend_clr_id),
    .pend_set    (pend_set),
    .pend_set_id (pend_set_id)
  );

  // Configuration registers and registered read-back
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
      if_enable  <= 1'b0;
      prio_mask  <= MASK_RESET;
    end else begin
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
      unique case (op)
        OP_RD_CTRL:  begin bus_rdata <= DATA_W'(if_enable); bus_rvalid <= 1'b1; end
        OP_RD_MASK:  begin bus_rdata <= DATA_W'(prio_mask); bus_rvalid <= 1'b1; end
        OP_RD_BPT:   begin bus_rdata <= '0;                 bus_rvalid <= 1'b1; end
        OP_RD_ACK:   begin
          bus_rdata  <= ack_ok ? DATA_W'(hp_id) : DATA_W'(NO_IRQ);
          bus_rvalid <= 1'b1;
        end
        OP_RD_RPRI:  begin bus_rdata <= DATA_W'(run_prio);  bus_rvalid <= 1'b1; end
        OP_RD_HPEND: begin bus_rdata <= DATA_W'(hp_id);     bus_rvalid <= 1'b1; end
        OP_WR_CTRL:  if_enable <= bus_wdata[0];
        OP_WR_MASK:  prio_mask <= bus_wdata[ID_W-1:0];
        OP_BAD_RD:   begin bus_rdata <= '0; bus_rvalid <= 1'b1; bus_err <= 1'b1; end
        OP_BAD_WR:   bus_err <= 1'b1;
        default: ;
      endcase
    end
  end

  a_r12_error_alone: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> !pend_clr && !pend_set);

  a_r11_no_accept_when_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && (bus_rd || bus_wr)) |=> !bus_rvalid && !bus_err);

  a_r2_mask_holds: assert property (@(posedge clk) disable iff (rst)
    (op != OP_WR_MASK) |=> $stable(prio_mask));
endmodule

// File: tb/tb_irq_cpu_if.sv
`timescale 1ns/1ps
module tb_irq_cpu_if;
  localparam int N  = 8;
  localparam int PW = 8;
  localparam int A_CTRL = 'h00, A_MASK = 'h04, A_BPT = 'h08, A_ACK = 'h0C;
  localparam int A_EOI = 'h10, A_RPRI = 'h14, A_HPEND = 'h18;
  localparam int NONE = 1023;

  logic clk = 0, rst = 1;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, bus_err, busy;
  logic [9:0] hp_id = 10'h3FF;
  logic [PW-1:0] hp_prio = 0;
  logic [N*PW-1:0] src_prio;
  logic [N-1:0] src_edge = 0, src_en = 0, src_level = 0;
  logic pend_clr, pend_set, if_enable;
  logic [9:0] pend_clr_id, pend_set_id, run_id, prio_mask;
  logic [PW:0] run_prio;

  int checks = 0, errors = 0;
  int stk[16];
  int sd = 0;

  always #2.5 clk = ~clk;

  irq_cpu_if #(.NUM_SRC(N), .PRIO_W(PW)) dut (.*);

  function automatic int pri(input int id);
    return (id == NONE) ? 256 : 8 * (N - id);
  endfunction

  initial for (int i = 0; i < N; i++) src_prio[i*PW +: PW] = PW'(8 * (N - i));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    wait_idle();
    bus_rd = 1; bus_addr = 8'(a);
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    wait_idle();
    bus_wr = 1; bus_addr = 8'(a); bus_wdata = v;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic claim(input int id, input int p, input bit ok);
    logic [31:0] d;
    hp_id = 10'(id); hp_prio = PW'(p);
    rd(A_ACK, d);
    if (ok) begin
      chk("R4 ack data", d, id);
      chk("R4 clear pulse", pend_clr, 1);
      chk("R4 clear id", pend_clr_id, id);
      chk("R4 run id", run_id, id);
      chk("R4 run prio", run_prio, p);
      stk[sd] = id; sd++;
    end else begin
      chk("R3 ack refused", d, NONE);
      chk("R3 no clear", pend_clr, 0);
    end
    hp_id = 10'h3FF;
  endtask

  task automatic retire(input int id, input logic [31:0] hi);
    wr(A_EOI, hi | 32'(id));
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int tgt, exp_set, mask_now;
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R1 run id", run_id, NONE);
    chk("R1 run prio", run_prio, 256);
    chk("R1 busy", busy, 0);
    chk("R1 clear", pend_clr, 0);
    chk("R1 enable", if_enable, 0);
    rd(A_MASK, d); chk("R1 mask reset", d, 'hF0);

    // R2 control and mask
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); chk("R2 enable set", d, 1);
    wr(A_CTRL, 32'h2); rd(A_CTRL, d); chk("R2 enable clear", d, 0);
    wr(A_MASK, 32'hFFFF_F123); rd(A_MASK, d); chk("R2 mask 10 bit", d, 'h123);
    wr(A_BPT, 32'h55); rd(A_BPT, d); chk("R2 bpt zero", d, 0);
    rd(A_MASK, d); chk("R2 bpt write no effect", d, 'h123);
    mask_now = 'h123;

    // R3 and R5
    claim(NONE, 0, 0);
    chk("R3 run unchanged", run_id, NONE);
    claim(2, pri(2), 1);
    claim(5, pri(2), 0);
    claim(5, pri(2) + 1, 0);
    chk("R3 run kept", run_id, 2);
    rd(A_RPRI, d); chk("R5 running prio", d, pri(2));
    hp_id = 10'd6; rd(A_HPEND, d); chk("R5 highest pending", d, 6); hp_id = 10'h3FF;
    claim(5, pri(2) - 1, 1);
    // R13 upper bits ignored
    retire(5, 32'hABCD_FC00); sd--;
    chk("R13 high bits ignored", run_id, 2);
    retire(2, 0); sd--;
    chk("R8 back to idle", run_id, NONE);
    chk("R8 idle prio", run_prio, 256);

    // R6 completion with nothing running
    src_edge = 0; src_en = '1; src_level = '1;
    wr(A_EOI, 32'd3);
    chk("R6 no set", pend_set, 0);
    chk("R6 not busy", busy, 0);
    chk("R6 run idle", run_id, NONE);

    // R7/R8/R9 sweep over depth and retire position
    for (int dp = 1; dp <= N; dp++) begin
      for (int p = 0; p < dp; p++) begin
        src_edge  = N'(dp * 37);
        src_level = N'(p * 91 + dp * 5);
        src_en    = ~N'(dp * 13);
        sd = 0;
        for (int i = 0; i < dp; i++) claim(i, pri(i), 1);
        tgt = stk[p];
        exp_set = (src_en[tgt] && !src_edge[tgt] && src_level[tgt]) ? 1 : 0;
        wr(A_EOI, 32'(tgt));
        chk("R7 set pulse", pend_set, exp_set);
        if (exp_set == 1) chk("R7 set id", pend_set_id, tgt);
        wait_idle();
        if (p == dp - 1) begin
          sd--;
          chk("R8 pop", run_id, (sd > 0) ? stk[sd-1] : NONE);
          chk("R8 pop prio", run_prio, pri((sd > 0) ? stk[sd-1] : NONE));
        end else begin
          for (int k = p; k < sd - 1; k++) stk[k] = stk[k+1];
          sd--;
          chk("R9 running kept", run_id, stk[sd-1]);
        end
        while (sd > 0) begin
          retire(stk[sd-1], 0);
          sd--;
          chk("R9 chain order", run_id, (sd > 0) ? stk[sd-1] : NONE);
          chk("R8 prio after pop", run_prio, pri((sd > 0) ? stk[sd-1] : NONE));
        end
      end
    end

    // R10 names outside the chain
    src_en = 0; sd = 0;
    claim(0, pri(0), 1); claim(1, pri(1), 1); claim(2, pri(2), 1);
    retire(6, 0);
    chk("R10 absent id keeps run", run_id, 2);
    retire(NONE, 0);
    chk("R10 idle id keeps run", run_id, 2);
    retire(2, 0); chk("R10 chain intact a", run_id, 1);

    // R11 busy and dropped strobe
    bus_wr = 1; bus_addr = 8'(A_EOI); bus_wdata = 32'd1;
    @(negedge clk);
    chk("R11 busy raised", busy, 1);
    bus_addr = 8'(A_MASK); bus_wdata = 32'h3;
    @(negedge clk);
    bus_wr = 0;
    wait_idle();
    chk("R11 pop done", run_id, 0);
    rd(A_MASK, d); chk("R11 strobe dropped", d, mask_now);
    retire(0, 0); chk("R10 chain intact b", run_id, NONE);

    // R12 bad offsets
    rd('h20, d); chk("R12 bad read data", d, 0); chk("R12 bad read err", bus_err, 1);
    rd(A_EOI, d); chk("R12 write-only read err", bus_err, 1);
    claim(3, pri(3), 1);
    wr(A_ACK, 32'd0); chk("R12 read-only write err", bus_err, 1);
    chk("R12 no state change", run_id, 3);
    wr('h30, 32'hFFFF); chk("R12 bad write err", bus_err, 1);
    rd(A_MASK, d); chk("R12 mask untouched", d, mask_now);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule